// File: doc/BRIEF.md
# Dual-Channel ADC Clamp and Output Back End

This block is the digital logic behind a pair of 8-bit converter cores that run from one sample clock. Each clock it takes one raw offset-binary sample per channel, delays it through a fixed two-register pipeline, and presents it on a tri-stateable output bus. The bus shows offset binary or two's complement, a test pattern, or high impedance, depending on the control inputs.

Alongside the data path, each channel runs a black-level clamp loop. The loop watches a clamp pulse whose active level is programmable. On the first active cycle of each pulse, it compares the incoming sample with a target code chosen by a 3-bit select. It then nudges that channel's 8-bit correction-DAC code one step toward the target. Both channels share the pulse, the polarity, the enable and the target select, but each keeps its own DAC code. The chosen target is also shown on a port, in whichever output format is selected.

A shared sequencer tracks the pulse in three named states:
- `CS_IDLE`: waiting for the pulse. It leaves to `CS_ACTIVE` when the pulse turns active with the enable high, which fires one step. It leaves to `CS_BLOCKED` when the pulse turns active with the enable low, which fires no step.
- `CS_ACTIVE` and `CS_BLOCKED`: both return to `CS_IDLE` once the pulse goes inactive.

The pattern generator has three states:
- `PAT_OFF` while test is low.
- On entering test mode it goes to `PAT_HI`, then alternates `PAT_HI` and `PAT_LO` for as long as test stays high.
- Any state returns to `PAT_OFF` when test drops.

Top module: `adc_clamp_backend`

## Requirements
- R1: A sample on `samp_a`/`samp_b` at clock edge N appears on `out_a`/`out_b` after edge N+1, so there are two register stages on both channels.
- R2: With `fmt_twos` low, the output bus carries the delayed sample unchanged (offset binary: 0 is bottom of scale, 255 is top).
- R3: With `fmt_twos` high, the output bus carries the delayed sample with bit 7 inverted. The format is applied at the output, so it follows the current `fmt_twos`.
- R4: With `fmt_twos` low, `clamp_ref` shows the target for `ref_sel` values 0..7 as 1, 16, 32, 128, 254, 239, 223 and 127.
- R5: With `fmt_twos` high, `clamp_ref` shows the same target with bit 7 inverted (select 0 gives 8'h81, select 3 gives 8'h00).
- R6: `pulse_pol` high makes `clamp_pulse` active-high, and `pulse_pol` low makes it active-low.
- R7: Each pulse gives at most one correction. On the edge where the pulse is first seen active, a DAC code increments if the sample is below the target, decrements if above, and holds if equal. Later cycles of the same pulse leave it unchanged.
- R8: DAC codes saturate at 0 and 255 and never wrap.
- R9: If `clamp_en` is low when a pulse starts, that whole pulse causes no correction, even if the enable rises during it.
- R10: The two channels' DAC codes move independently, each from its own sample.
- R11: Output priority: `test_en` high drives the test pattern regardless of `standby`. Otherwise `standby` high releases both buses to high impedance (`out_en` low). Otherwise data is driven.
- R12: In test mode the buses show 8'h55 in the first cycle and then alternate 8'hAA and 8'h55 on every clock edge.
- R13: Synchronous reset sets both DAC codes to 128 and clears the pipeline, so the buses read 0 in offset binary.
- R14: The clamp comparison always uses the raw offset-binary sample against the offset-binary target, whatever `fmt_twos` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared sample clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_a | input | 8 | Raw offset-binary sample, channel A |
| samp_b | input | 8 | Raw offset-binary sample, channel B |
| clamp_pulse | input | 1 | Clamp pulse |
| pulse_pol | input | 1 | 1: pulse active high, 0: active low |
| clamp_en | input | 1 | Clamp loop enable |
| ref_sel | input | 3 | Clamp target select |
| fmt_twos | input | 1 | 1: two's complement, 0: offset binary |
| standby | input | 1 | Release output buses |
| test_en | input | 1 | Drive test pattern |
| out_a | output | 8 | Channel A output bus (tri-state) |
| out_b | output | 8 | Channel B output bus (tri-state) |
| out_en | output | 1 | High when the buses are driven |
| dac_a | output | 8 | Correction-DAC code, channel A |
| dac_b | output | 8 | Correction-DAC code, channel B |
| clamp_ref | output | 8 | Selected target in the current format |

## Verification
The assertions assume that the reset is held across the first clock edge, so every `$past` value is a defined post-reset value. They also assume that `pulse_pol` changes only while the pulse sits at the level that is inactive under the new polarity, so that flipping the polarity never fakes a pulse start. The stimulus follows both rules: reset is raised at time zero, and the polarity and the pulse level are switched together on the same falling edge. All inputs change only on falling clock edges, so the sequencer sees each pulse start on exactly one rising edge.

// File: rtl/adc_clamp_pkg.sv
package adc_clamp_pkg;
    typedef enum logic [1:0] {
        CS_IDLE    = 2'd0,
        CS_ACTIVE  = 2'd1,
        CS_BLOCKED = 2'd2
    } clamp_state_t;

    typedef enum logic [1:0] {
        PAT_OFF = 2'd0,
        PAT_HI  = 2'd1,
        PAT_LO  = 2'd2
    } pat_state_t;
endpackage

// File: rtl/clamp_target.sv
module clamp_target #(
    parameter int DW    = 8,
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0] sel,
    output logic [DW-1:0]    target
);
    localparam logic [DW-1:0] ONE  = DW'(1);
    localparam logic [DW-1:0] LOW4 = ONE << (DW - 4);
    localparam logic [DW-1:0] LOW3 = ONE << (DW - 3);
    localparam logic [DW-1:0] MID  = ONE << (DW - 1);

    logic [DW-1:0] base;

    // The upper half of the table mirrors the lower half about full scale.
    always_comb begin
        unique case (sel[1:0])
            2'd0:    base = ONE;
            2'd1:    base = LOW4;
            2'd2:    base = LOW3;
            default: base = MID;
        endcase
        target = sel[2] ? ~base : base;
    end
endmodule

// File: rtl/clamp_seq.sv
module clamp_seq
    import adc_clamp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clamp_pulse,
    input  logic pulse_pol,
    input  logic clamp_en,
    output logic do_step
);
    clamp_state_t state, state_nx;
    logic         act;

    assign act = pulse_pol ? clamp_pulse : ~clamp_pulse;

    always_comb begin
        state_nx = state;
        unique case (state)
            CS_IDLE:    if (act) state_nx = clamp_en ? CS_ACTIVE : CS_BLOCKED;
            CS_ACTIVE:  if (!act) state_nx = CS_IDLE;
            CS_BLOCKED: if (!act) state_nx = CS_IDLE;
            default:    state_nx = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CS_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        do_step = 1'b0;
        unique case (state)
            CS_IDLE:    do_step = act && clamp_en;
            CS_ACTIVE:  do_step = 1'b0;
            CS_BLOCKED: do_step = 1'b0;
            default:    do_step = 1'b0;
        endcase
    end

    assert_single_step_R7: assert property (@(posedge clk) disable iff (rst)
        do_step |=> !do_step);
    assert_blocked_no_step_R9: assert property (@(posedge clk) disable iff (rst)
        (state == CS_BLOCKED) |-> !do_step);
    assert_pulse_leaves_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (state == CS_IDLE && act) |=> (state != CS_IDLE));
endmodule

// File: rtl/clamp_step.sv
module clamp_step #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          do_step,
    input  logic [DW-1:0] sample,
    input  logic [DW-1:0] target,
    output logic [DW-1:0] code
);
    localparam logic [DW-1:0] MID  = DW'(1) << (DW - 1);
    localparam logic [DW-1:0] FULL = '1;
    localparam logic [DW-1:0] ZERO = '0;

    logic [DW-1:0] code_nx;

    always_comb begin
        code_nx = code;
        if (do_step) begin
            if (sample < target && code != FULL)      code_nx = code + DW'(1);
            else if (sample > target && code != ZERO) code_nx = code - DW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) code <= MID;
        else     code <= code_nx;
    end

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !do_step |=> $stable(code));
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> !((code == ZERO && $past(code) == FULL) ||
                   (code == FULL && $past(code) == ZERO)));
    assert_equal_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (sample == target) |=> $stable(code));
endmodule

// File: rtl/sample_pipe.sv
module sample_pipe #(
    parameter int DW  = 8,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] stg [LAT];

    for (genvar i = 0; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)         stg[i] <= '0;
            else if (i == 0) stg[i] <= din;
            else             stg[i] <= stg[(i == 0) ? 0 : i - 1];
        end
    end

    assign dout = stg[LAT-1];

    if (LAT == 2) begin : g_chk
        assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> ##1 (dout == $past(din, 2)));
    end
endmodule

// File: rtl/out_ctrl.sv
module out_ctrl
    import adc_clamp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          test_en,
    input  logic          standby,
    input  logic          fmt_twos,
    input  logic [DW-1:0] data_a,
    input  logic [DW-1:0] data_b,
    output logic [DW-1:0] bus_a,
    output logic [DW-1:0] bus_b,
    output logic          bus_oe
);
    localparam logic [DW-1:0] PAT_5 = {(DW/2){2'b01}};
    localparam logic [DW-1:0] PAT_A = {(DW/2){2'b10}};
    localparam logic [DW-1:0] MSB   = DW'(1) << (DW - 1);

    pat_state_t    pst, pst_nx;
    logic [DW-1:0] pattern;
    logic [DW-1:0] fmt_mask;

    always_comb begin
        pst_nx = pst;
        unique case (pst)
            PAT_OFF: pst_nx = test_en ? PAT_HI : PAT_OFF;
            PAT_HI:  pst_nx = test_en ? PAT_LO : PAT_OFF;
            PAT_LO:  pst_nx = test_en ? PAT_HI : PAT_OFF;
            default: pst_nx = PAT_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pst <= PAT_OFF;
        else     pst <= pst_nx;
    end

    always_comb begin
        fmt_mask = fmt_twos ? MSB : '0;
        unique case (pst)
            PAT_HI:  pattern = PAT_A;
            default: pattern = PAT_5;
        endcase
        if (test_en) begin
            bus_a  = pattern;
            bus_b  = pattern;
            bus_oe = 1'b1;
        end else begin
            bus_a  = data_a ^ fmt_mask;
            bus_b  = data_b ^ fmt_mask;
            bus_oe = !standby;
        end
    end

    assert_pattern_toggles_R12: assert property (@(posedge clk) disable iff (rst)
        (test_en && $past(test_en)) |-> (pattern != $past(pattern)));
    assert_pattern_start_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(test_en) |-> (bus_a == PAT_5));
endmodule

// File: rtl/adc_clamp_backend.sv
module adc_clamp_backend #(
    parameter int DW    = 8,
    parameter int SEL_W = 3,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DW-1:0]    samp_a,
    input  logic [DW-1:0]    samp_b,
    input  logic             clamp_pulse,
    input  logic             pulse_pol,
    input  logic             clamp_en,
    input  logic [SEL_W-1:0] ref_sel,
    input  logic             fmt_twos,
    input  logic             standby,
    input  logic             test_en,
    output logic [DW-1:0]    out_a,
    output logic [DW-1:0]    out_b,
    output logic             out_en,
    output logic [DW-1:0]    dac_a,
    output logic [DW-1:0]    dac_b,
    output logic [DW-1:0]    clamp_ref
);
    localparam logic [DW-1:0] MSB = DW'(1) << (DW - 1);

    logic [DW-1:0] target_ob;
    logic          do_step;
    logic [DW-1:0] pipe_a, pipe_b;
    logic [DW-1:0] bus_a, bus_b;
    logic          bus_oe;

    clamp_target #(.DW(DW), .SEL_W(SEL_W)) u_target (
        .sel    (ref_sel),
        .target (target_ob)
    );

    clamp_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .clamp_pulse (clamp_pulse),
        .pulse_pol   (pulse_pol),
        .clamp_en    (clamp_en),
        .do_step     (do_step)
    );

    clamp_step #(.DW(DW)) u_step_a (
        .clk (clk), .rst (rst), .do_step (do_step),
        .sample (samp_a), .target (target_ob), .code (dac_a)
    );

    clamp_step #(.DW(DW)) u_step_b (
        .clk (clk), .rst (rst), .do_step (do_step),
        .sample (samp_b), .target (target_ob), .code (dac_b)
    );

    sample_pipe #(.DW(DW), .LAT(LAT)) u_pipe_a (
        .clk (clk), .rst (rst), .din (samp_a), .dout (pipe_a)
    );

    sample_pipe #(.DW(DW), .LAT(LAT)) u_pipe_b (
        .clk (clk), .rst (rst), .din (samp_b), .dout (pipe_b)
    );

    out_ctrl #(.DW(DW)) u_out (
        .clk      (clk),
        .rst      (rst),
        .test_en  (test_en),
        .standby  (standby),
        .fmt_twos (fmt_twos),
        .data_a   (pipe_a),
        .data_b   (pipe_b),
        .bus_a    (bus_a),
        .bus_b    (bus_b),
        .bus_oe   (bus_oe)
    );

    assign clamp_ref = fmt_twos ? (target_ob ^ MSB) : target_ob;
    assign out_en    = bus_oe;
    assign out_a     = bus_oe ? bus_a : 'z;
    assign out_b     = bus_oe ? bus_b : 'z;

    assert_disabled_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!clamp_en && !do_step) |=> ($stable(dac_a) && $stable(dac_b)));
    assert_test_wins_R11: assert property (@(posedge clk) disable iff (rst)
        test_en |-> out_en);
    assert_standby_release_R11: assert property (@(posedge clk) disable iff (rst)
        (standby && !test_en) |-> !out_en);
    assert_twos_ref_R5: assert property (@(posedge clk) disable iff (rst)
        fmt_twos |-> (clamp_ref[DW-1] != target_ob[DW-1]));
endmodule

// File: tb/adc_clamp_backend_tb.sv
`timescale 1ns/1ps
module adc_clamp_backend_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] samp_a, samp_b;
    logic       clamp_pulse, pulse_pol, clamp_en, fmt_twos, standby, test_en;
    logic [2:0] ref_sel;
    logic [7:0] out_a, out_b, dac_a, dac_b, clamp_ref;
    logic       out_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    localparam logic [7:0] REF_T [8] = '{8'd1, 8'd16, 8'd32, 8'd128,
                                         8'd254, 8'd239, 8'd223, 8'd127};
    localparam int NV = 10;
    // {fmt, a, b}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'h00, 8'hFF}, {1'b0, 8'h12, 8'h34}, {1'b1, 8'h80, 8'h7F},
        {1'b1, 8'hFF, 8'h00}, {1'b0, 8'h5A, 8'hA5}, {1'b1, 8'h01, 8'hFE},
        {1'b0, 8'h7F, 8'h80}, {1'b1, 8'h3C, 8'hC3}, {1'b0, 8'hAA, 8'h55},
        {1'b1, 8'h10, 8'hEF}};

    always #2.5 clk = ~clk;

    adc_clamp_backend u_dut (
        .clk(clk), .rst(rst), .samp_a(samp_a), .samp_b(samp_b),
        .clamp_pulse(clamp_pulse), .pulse_pol(pulse_pol), .clamp_en(clamp_en),
        .ref_sel(ref_sel), .fmt_twos(fmt_twos), .standby(standby),
        .test_en(test_en), .out_a(out_a), .out_b(out_b), .out_en(out_en),
        .dac_a(dac_a), .dac_b(dac_b), .clamp_ref(clamp_ref)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    // one clamp pulse: active for hold cycles, then inactive one cycle
    task automatic pulse(input int hold);
        clamp_pulse = pulse_pol;
        repeat (hold) nxt();
        clamp_pulse = ~pulse_pol;
        nxt();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; samp_a = 8'd0; samp_b = 8'd0; clamp_pulse = 1'b0;
        pulse_pol = 1'b1; clamp_en = 1'b1; ref_sel = 3'd3; fmt_twos = 1'b0;
        standby = 1'b0; test_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        nxt();
        // R13 reset state
        chk("R13 dac_a", dac_a, 8'd128);
        chk("R13 dac_b", dac_b, 8'd128);
        chk("R13 out_a", out_a, 8'd0);
        chk("R13 out_b", out_b, 8'd0);

        // R4 / R5 reference table
        for (int s = 0; s < 8; s++) begin
            ref_sel = 3'(s); fmt_twos = 1'b0; #1;
            chk("R4 clamp_ref", clamp_ref, REF_T[s]);
            fmt_twos = 1'b1; #1;
            chk("R5 clamp_ref", clamp_ref, REF_T[s] ^ 8'h80);
        end
        nxt();

        // R1 / R2 / R3 vector walk
        for (int i = 0; i < NV + 2; i++) begin
            if (i >= 2) begin
                automatic logic       f = VEC[(i - 1 < NV) ? i - 1 : NV - 1][16];
                automatic logic [7:0] m = f ? 8'h80 : 8'h00;
                chk(f ? "R1 R3 out_a" : "R1 R2 out_a", out_a, VEC[i-2][15:8] ^ m);
                chk(f ? "R1 R3 out_b" : "R1 R2 out_b", out_b, VEC[i-2][7:0] ^ m);
            end
            if (i < NV) begin
                fmt_twos = VEC[i][16]; samp_a = VEC[i][15:8]; samp_b = VEC[i][7:0];
            end
            nxt();
        end

        // R7 clamp steps, target 128
        fmt_twos = 1'b0; ref_sel = 3'd3; samp_a = 8'd100; samp_b = 8'd200;
        pulse(3);
        chk("R7 up dac_a", dac_a, 8'd129);
        chk("R7 down dac_b", dac_b, 8'd127);
        samp_a = 8'd128; samp_b = 8'd128;
        pulse(1);
        chk("R7 equal dac_a", dac_a, 8'd129);
        chk("R7 equal dac_b", dac_b, 8'd127);
        // R10 independence
        samp_a = 8'd100;
        pulse(2);
        chk("R10 dac_a", dac_a, 8'd130);
        chk("R10 dac_b", dac_b, 8'd127);
        // R14 format does not affect comparison
        fmt_twos = 1'b1; samp_a = 8'd100; samp_b = 8'd200;
        pulse(1);
        chk("R14 dac_a", dac_a, 8'd131);
        chk("R14 dac_b", dac_b, 8'd126);
        fmt_twos = 1'b0;
        // R9 disabled pulse, enable rising mid-pulse
        clamp_en = 1'b0; samp_a = 8'd0;
        pulse(2);
        chk("R9 dac_a", dac_a, 8'd131);
        clamp_pulse = 1'b1; nxt(); clamp_en = 1'b1; nxt(); nxt();
        clamp_pulse = 1'b0; nxt();
        chk("R9 mid-pulse enable dac_a", dac_a, 8'd131);
        // R6 active-low polarity
        pulse_pol = 1'b0; clamp_pulse = 1'b1; nxt(); nxt();
        chk("R6 high inactive dac_a", dac_a, 8'd131);
        pulse(1);
        chk("R6 low active dac_a", dac_a, 8'd132);
        pulse_pol = 1'b1; clamp_pulse = 1'b0; nxt();
        // R8 saturation, target 254
        ref_sel = 3'd4; samp_a = 8'd0; samp_b = 8'd255;
        for (int k = 0; k < 140; k++) pulse(1);
        chk("R8 top dac_a", dac_a, 8'd255);
        chk("R8 bottom dac_b", dac_b, 8'd0);

        // R11 / R12 output priority and pattern
        nxt();
        standby = 1'b1; #1;
        chk("R11 standby out_en", {7'd0, out_en}, 8'd0);
        nxt();
        test_en = 1'b1; #1;
        chk("R11 test over standby out_en", {7'd0, out_en}, 8'd1);
        chk("R12 first out_a", out_a, 8'h55);
        nxt();
        chk("R12 second out_a", out_a, 8'hAA);
        chk("R12 second out_b", out_b, 8'hAA);
        nxt();
        chk("R12 third out_a", out_a, 8'h55);
        test_en = 1'b0; standby = 1'b0; #1;
        chk("R11 data out_a", out_a, 8'h00);
        chk("R11 data out_b", out_b, 8'hFF);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule